// File: doc/BRIEF.md
# Video Sync Lock Qualifier

This block decides whether incoming video should be reported as locked. Each video line, signalled by a one-cycle strobe, it samples a qualifying condition. That condition comes from one of two raw lock indications. The first is a fast horizontal-sync check made line by line. The second is a slower indication that spans several fields and takes vertical sync into account. The condition can also be required to include colour-subcarrier lock. Hysteresis counted in lines stops a brief glitch from toggling the reported state.

Entering lock needs a run of consecutive qualifying lines, and leaving lock needs a run of consecutive failing lines. Each run length is set by its own 3-bit code, and the code-to-length mapping is non-linear. All inputs are plain synchronous control and status bits: there is no data stream and no back-pressure. The codes are expected to be driven from configuration registers whose reset value is 3'b100 (100 lines).

Top module: `line_lock_qual`

## Requirements
- R1: After reset, `locked` is 0 and `lock_status` is 2'b00.
- R2: With `src_sel` = 0, the raw lock is `slow_lock`, and `fast_lock` has no effect on `locked`.
- R3: With `src_sel` = 1, the raw lock is `fast_lock`, and `slow_lock` has no effect on `locked`.
- R4: With `subc_en` = 0, the qualifying condition is the raw lock alone, and `subc_lock` has no effect.
- R5: With `subc_en` = 1, the qualifying condition is the raw lock AND `subc_lock`.
- R6: While unlocked, `locked` rises after `enter_code` maps to N and the condition has been true on N consecutive strobed lines. The map is 000→1, 001→2, 010→5, 011→10, 100→100, 101→500, 110→1000, 111→100000.
- R7: While locked, `locked` falls after the condition has been false on M consecutive strobed lines, where M is `leave_code` under the same map.
- R8: A strobed line that breaks the run restarts the count from zero, for both entering and leaving lock.
- R9: Only cycles with `line_stb` = 1 count as lines. Condition values in other cycles have no effect, and `locked` changes only in the cycle after a strobe.
- R10: `lock_status` is 2'b01 while locked and 2'b00 while unlocked, and it changes on the same clock edge as `locked`.
- R11: A change of a count code takes effect at the next strobed comparison, against the run already accumulated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_stb | input | 1 | One-cycle pulse per video line |
| fast_lock | input | 1 | Line-by-line horizontal-sync lock indication |
| slow_lock | input | 1 | Multi-field lock indication |
| subc_lock | input | 1 | Colour-subcarrier lock flag |
| src_sel | input | 1 | Raw lock select: 0 slow, 1 fast |
| subc_en | input | 1 | Also require subcarrier lock when 1 |
| enter_code | input | 3 | Line-count code for entering lock |
| leave_code | input | 3 | Line-count code for leaving lock |
| locked | output | 1 | Registered lock state |
| lock_status | output | 2 | 2'b01 locked, 2'b00 unlocked |

## Verification
The hardest case to reach is the longest run, code 111, which needs 100000 consecutive qualifying lines. The bench holds `line_stb` high on every cycle for that run. It checks that the state is still unlocked after 99999 lines and locked after one more. A second hard case is a code change in the middle of a run. To reach it, the bench builds up a partial count under a long code and then switches to a shorter code, so a single further line must complete the threshold.

// File: rtl/lockq_pkg.sv
package lockq_pkg;

  typedef enum logic {
    ST_UNLOCKED = 1'b0,
    ST_LOCKED   = 1'b1
  } lock_state_t;

  localparam logic [1:0] STATUS_LOCKED   = 2'b01;
  localparam logic [1:0] STATUS_UNLOCKED = 2'b00;

  // Non-linear run-length map shared by both directions.
  function automatic logic [31:0] code_lines(input logic [2:0] code);
    logic [31:0] n;
    case (code)
      3'd0:    n = 32'd1;
      3'd1:    n = 32'd2;
      3'd2:    n = 32'd5;
      3'd3:    n = 32'd10;
      3'd4:    n = 32'd100;
      3'd5:    n = 32'd500;
      3'd6:    n = 32'd1000;
      default: n = 32'd100000;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/lockq_cond.sv
module lockq_cond (
  input  logic fast_lock,
  input  logic slow_lock,
  input  logic subc_lock,
  input  logic src_sel,
  input  logic subc_en,
  output logic cond
);
  logic raw_lock;

  always_comb begin
    raw_lock = src_sel ? fast_lock : slow_lock;
    cond     = raw_lock & (subc_lock | ~subc_en);
  end
endmodule

// File: rtl/lockq_thresh.sv
module lockq_thresh
  import lockq_pkg::*;
#(
  parameter int CNT_W = 17
) (
  input  logic [2:0]       code,
  output logic [CNT_W-1:0] lines
);
  logic [31:0] full;

  always_comb begin
    full  = code_lines(code);
    lines = full[CNT_W-1:0];
  end
endmodule

// File: rtl/lockq_hyst.sv
module lockq_hyst
  import lockq_pkg::*;
#(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_stb,
  input  logic             cond,
  input  logic [CNT_W-1:0] need_in,
  input  logic [CNT_W-1:0] need_out,
  output logic             locked,
  output logic [1:0]       status
);
  lock_state_t      state_q;
  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] run_nxt;
  logic             in_run;
  logic [CNT_W-1:0] need;

  always_comb begin
    run_nxt = run_q + 1'b1;
    // In-run means the line moves toward the opposite state.
    in_run  = (state_q == ST_UNLOCKED) ? cond : ~cond;
    need    = (state_q == ST_UNLOCKED) ? need_in : need_out;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_UNLOCKED;
      run_q   <= '0;
      status  <= STATUS_UNLOCKED;
    end else if (line_stb) begin
      if (!in_run) begin
        run_q <= '0;
      end else if (run_nxt >= need) begin
        run_q <= '0;
        if (state_q == ST_UNLOCKED) begin
          state_q <= ST_LOCKED;
          status  <= STATUS_LOCKED;
        end else begin
          state_q <= ST_UNLOCKED;
          status  <= STATUS_UNLOCKED;
        end
      end else begin
        run_q <= run_nxt;
      end
    end
  end

  assign locked = (state_q == ST_LOCKED);
endmodule

// File: rtl/line_lock_qual.sv
module line_lock_qual #(
  parameter int CNT_W = 17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_stb,
  input  logic       fast_lock,
  input  logic       slow_lock,
  input  logic       subc_lock,
  input  logic       src_sel,
  input  logic       subc_en,
  input  logic [2:0] enter_code,
  input  logic [2:0] leave_code,
  output logic       locked,
  output logic [1:0] lock_status
);
  logic             cond_w;
  logic [CNT_W-1:0] need_in_w;
  logic [CNT_W-1:0] need_out_w;

  lockq_cond cond_i (
    .fast_lock (fast_lock),
    .slow_lock (slow_lock),
    .subc_lock (subc_lock),
    .src_sel   (src_sel),
    .subc_en   (subc_en),
    .cond      (cond_w)
  );

  lockq_thresh #(.CNT_W(CNT_W)) th_in_i (
    .code  (enter_code),
    .lines (need_in_w)
  );

  lockq_thresh #(.CNT_W(CNT_W)) th_out_i (
    .code  (leave_code),
    .lines (need_out_w)
  );

  lockq_hyst #(.CNT_W(CNT_W)) hyst_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_stb (line_stb),
    .cond     (cond_w),
    .need_in  (need_in_w),
    .need_out (need_out_w),
    .locked   (locked),
    .status   (lock_status)
  );
endmodule

// File: rtl/lockq_chk.sv
module lockq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       line_stb,
  input logic       cond,
  input logic [2:0] enter_code,
  input logic [2:0] leave_code,
  input logic       locked,
  input logic [1:0] lock_status
);
  // R10
  status_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_status == {1'b0, locked});

  // R9
  strobe_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |=> $stable(locked));

  // R6
  rise_needs_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(cond));

  // R7
  fall_needs_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> !$past(cond));

  // R6
  single_line_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && line_stb && cond && enter_code == 3'b000) |=> locked);

  // R7
  single_line_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && line_stb && !cond && leave_code == 3'b000) |=> !locked);
endmodule

bind line_lock_qual lockq_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .line_stb    (line_stb),
  .cond        (cond_w),
  .enter_code  (enter_code),
  .leave_code  (leave_code),
  .locked      (locked),
  .lock_status (lock_status)
);

// File: tb/line_lock_qual_tb_top.sv
module line_lock_qual_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_stb = 1'b0;
  logic       fast_lock = 1'b0;
  logic       slow_lock = 1'b0;
  logic       subc_lock = 1'b0;
  logic       src_sel = 1'b0;
  logic       subc_en = 1'b0;
  logic [2:0] enter_code = 3'b100;
  logic [2:0] leave_code = 3'b100;
  logic       locked;
  logic [1:0] lock_status;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  line_lock_qual dut_i (
    .clk, .rst_n, .line_stb, .fast_lock, .slow_lock, .subc_lock,
    .src_sel, .subc_en, .enter_code, .leave_code, .locked, .lock_status
  );

  function automatic int lines_of(input logic [2:0] c);
    case (c)
      3'd0: return 1;     3'd1: return 2;    3'd2: return 5;
      3'd3: return 10;    3'd4: return 100;  3'd5: return 500;
      3'd6: return 1000;  default: return 100000;
    endcase
  endfunction

  task automatic check_lock(input string req, input logic exp);
    n_chk++;
    if (locked !== exp || lock_status !== {1'b0, exp}) begin
      n_bad++;
      $display("FAIL %s: locked=%b status=%b expected locked=%b status=%b",
               req, locked, lock_status, exp, {1'b0, exp});
    end
  endtask

  // Called at a negedge; returns at a negedge.
  task automatic run_lines(input int n);
    for (int i = 0; i < n; i++) begin
      line_stb = 1'b1;
      @(negedge clk);
    end
    line_stb = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; line_stb = 1'b0;
    fast_lock = 1'b0; slow_lock = 1'b0; subc_lock = 1'b0;
    src_sel = 1'b1; subc_en = 1'b0;
    enter_code = 3'b000; leave_code = 3'b000;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check_lock("R1 reset state", 1'b0);
  endtask

  task automatic t_enter_codes();
    for (int c = 0; c < 7; c++) begin
      do_reset();
      enter_code = 3'(c);
      fast_lock = 1'b1;
      if (lines_of(3'(c)) > 1) begin
        run_lines(lines_of(3'(c)) - 1);
        check_lock($sformatf("R6 code %0d one line short", c), 1'b0);
      end
      run_lines(1);
      check_lock($sformatf("R6 R10 code %0d reached", c), 1'b1);
    end
  endtask

  task automatic t_enter_max();
    do_reset();
    enter_code = 3'b111;
    fast_lock = 1'b1;
    run_lines(99999);
    check_lock("R6 code 7 one line short", 1'b0);
    run_lines(1);
    check_lock("R6 code 7 reached", 1'b1);
  endtask

  task automatic t_leave_codes();
    for (int c = 0; c < 6; c++) begin
      do_reset();
      fast_lock = 1'b1;
      run_lines(1);
      leave_code = 3'(c);
      fast_lock = 1'b0;
      if (lines_of(3'(c)) > 1) begin
        run_lines(lines_of(3'(c)) - 1);
        check_lock($sformatf("R7 code %0d one line short", c), 1'b1);
      end
      run_lines(1);
      check_lock($sformatf("R7 R10 code %0d reached", c), 1'b0);
    end
  endtask

  task automatic t_break();
    do_reset();
    enter_code = 3'b011;
    fast_lock = 1'b1; run_lines(9);
    fast_lock = 1'b0; run_lines(1);
    fast_lock = 1'b1; run_lines(9);
    check_lock("R8 entry run restarted", 1'b0);
    run_lines(1);
    check_lock("R8 entry run completes", 1'b1);
    leave_code = 3'b011;
    fast_lock = 1'b0; run_lines(9);
    fast_lock = 1'b1; run_lines(1);
    fast_lock = 1'b0; run_lines(9);
    check_lock("R8 exit run restarted", 1'b1);
    run_lines(1);
    check_lock("R8 exit run completes", 1'b0);
  endtask

  task automatic t_source();
    do_reset();
    src_sel = 1'b0; fast_lock = 1'b1; slow_lock = 1'b0;
    run_lines(3);
    check_lock("R2 fast ignored when slow selected", 1'b0);
    slow_lock = 1'b1; run_lines(1);
    check_lock("R2 slow source locks", 1'b1);
    src_sel = 1'b1; fast_lock = 1'b0; slow_lock = 1'b1;
    run_lines(1);
    check_lock("R3 slow ignored when fast selected", 1'b0);
    slow_lock = 1'b0; fast_lock = 1'b1; run_lines(1);
    check_lock("R3 fast source locks", 1'b1);
  endtask

  task automatic t_subc();
    do_reset();
    subc_en = 1'b0; subc_lock = 1'b0; fast_lock = 1'b1;
    run_lines(1);
    check_lock("R4 subcarrier ignored", 1'b1);
    do_reset();
    subc_en = 1'b1; subc_lock = 1'b0; fast_lock = 1'b1;
    run_lines(5);
    check_lock("R5 subcarrier required", 1'b0);
    subc_lock = 1'b1; run_lines(1);
    check_lock("R5 both locks present", 1'b1);
    subc_lock = 1'b0; run_lines(1);
    check_lock("R5 subcarrier loss unlocks", 1'b0);
  endtask

  task automatic t_strobe();
    do_reset();
    fast_lock = 1'b1;
    repeat (20) @(negedge clk);
    check_lock("R9 no strobe no lock", 1'b0);
    do_reset();
    enter_code = 3'b010;
    fast_lock = 1'b1; run_lines(4);
    fast_lock = 1'b0;
    repeat (10) @(negedge clk);
    fast_lock = 1'b1; run_lines(1);
    check_lock("R9 unstrobed break ignored", 1'b1);
  endtask

  task automatic t_code_change();
    do_reset();
    enter_code = 3'b100;
    fast_lock = 1'b1; run_lines(20);
    check_lock("R11 partial run under code 4", 1'b0);
    enter_code = 3'b011;
    run_lines(1);
    check_lock("R11 shorter code applies at once", 1'b1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_enter_codes();
    t_enter_max();
    t_leave_codes();
    t_break();
    t_source();
    t_subc();
    t_strobe();
    t_code_change();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule